// File: doc/BRIEF.md
# Three-Port Register File with Standby

A single-bank synchronous register file with one read port and two write ports on a shared clock. Each port has its own enable and address. Reads are registered: the word addressed at a rising edge appears on the read output after that edge and stays there until the next accepted read. Writes from both ports commit at the rising edge.

Two standby inputs gate the ports independently. Write standby makes both write ports ignore their enables, addresses and data, so the array is left untouched. Read standby makes the read port ignore its enable and address, and the read output keeps its last value. The block does not arbitrate same-address accesses. It detects them and raises a one-cycle flag aligned with the read output. In simulation the affected word or read result is made unknown. Users must keep the ports off each other's addresses.

Top module: `triport_regfile`

## Requirements
- R1: While rst_n is low and right after it rises, rd_data is 0 and clash_rw and clash_ww are 0. The array contents are not reset.
- R2: When rd_en=1 and rd_stby=0 at a rising edge, rd_data shows the word at rd_addr from after that edge. That word is the value written at an earlier edge.
- R3: With wr_stby=0, each write port whose enable is 1 at a rising edge stores its data at its address. Both ports write in the same cycle when their addresses differ.
- R4: While wr_stby=1, wr0_en, wr1_en, the write addresses and the write data are ignored, and no word of the array changes.
- R5: While rd_stby=1, rd_en and rd_addr are ignored and rd_data holds its value.
- R6: If at an edge the read port is active (rd_en=1, rd_stby=0) and an active write port (its enable 1, wr_stby=0) has an address equal to rd_addr, clash_rw is 1 for the cycle after that edge. The read result for that access is undefined.
- R7: If at an edge both write ports are active with equal addresses, clash_ww is 1 for the cycle after that edge. The target word becomes undefined.
- R8: The contention flags are 0 after any edge without the conditions of R6 or R7. This includes different addresses and any case where the colliding port is in standby.
- R9: When rd_en=0 at an edge, rd_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| rd_en | input | 1 | Read enable |
| rd_stby | input | 1 | Read standby |
| rd_addr | input | AW | Read address, AW = clog2(DEPTH) |
| wr_stby | input | 1 | Write standby for both write ports |
| wr0_en | input | 1 | Write port 0 enable |
| wr0_addr | input | AW | Write port 0 address |
| wr0_data | input | WIDTH | Write port 0 data |
| wr1_en | input | 1 | Write port 1 enable |
| wr1_addr | input | AW | Write port 1 address |
| wr1_data | input | WIDTH | Write port 1 data |
| rd_data | output | WIDTH | Registered read data |
| clash_rw | output | 1 | Read/write same-address flag, one cycle |
| clash_ww | output | 1 | Write/write same-address flag, one cycle |

## Verification
The hardest case is a collision that should not be flagged. A standby input hides a port that would otherwise match the other port's address. This cannot be seen from the flags alone, so the stimulus sets up exact address matches with one side in standby. It then reads the target words back to show they kept their earlier contents. Real collisions are followed by a rewrite of the damaged word before it is read again, because its content is undefined. This lets the scoreboard keep a known model of the whole array.

// File: rtl/triport_regfile.sv
module triport_regfile #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             rd_stby,
  input  logic [AW-1:0]    rd_addr,
  input  logic             wr_stby,
  input  logic             wr0_en,
  input  logic [AW-1:0]    wr0_addr,
  input  logic [WIDTH-1:0] wr0_data,
  input  logic             wr1_en,
  input  logic [AW-1:0]    wr1_addr,
  input  logic [WIDTH-1:0] wr1_data,
  output logic [WIDTH-1:0] rd_data,
  output logic             clash_rw,
  output logic             clash_ww
);

  logic [WIDTH-1:0] mem [DEPTH];

  wire rd_go  = rd_en & ~rd_stby;
  wire w0_go  = wr0_en & ~wr_stby;
  wire w1_go  = wr1_en & ~wr_stby;
  wire hit_rw = rd_go & ((w0_go & (wr0_addr == rd_addr)) |
                         (w1_go & (wr1_addr == rd_addr)));
  wire hit_ww = w0_go & w1_go & (wr0_addr == wr1_addr);

  always_ff @(posedge clk) begin
    if (hit_ww) begin
      mem[wr0_addr] <= 'x;
    end else begin
      if (w0_go) mem[wr0_addr] <= wr0_data;
      if (w1_go) mem[wr1_addr] <= wr1_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      clash_rw <= 1'b0;
      clash_ww <= 1'b0;
    end else begin
      clash_rw <= hit_rw;
      clash_ww <= hit_ww;
      if (rd_go) rd_data <= hit_rw ? 'x : mem[rd_addr];
    end
  end

endmodule

// File: rtl/triport_regfile_chk.sv
module triport_regfile_chk #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             rd_stby,
  input logic [AW-1:0]    rd_addr,
  input logic             wr_stby,
  input logic             wr0_en,
  input logic [AW-1:0]    wr0_addr,
  input logic             wr1_en,
  input logic [AW-1:0]    wr1_addr,
  input logic [WIDTH-1:0] rd_data,
  input logic             clash_rw,
  input logic             clash_ww
);

  logic rw_cond, ww_cond;
  always_comb begin
    rw_cond = rd_en && !rd_stby && !wr_stby &&
              ((wr0_en && wr0_addr == rd_addr) || (wr1_en && wr1_addr == rd_addr));
    ww_cond = !wr_stby && wr0_en && wr1_en && (wr0_addr == wr1_addr);
  end

  AST_RW_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) rw_cond |=> clash_rw); // R6
  AST_WW_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) ww_cond |=> clash_ww); // R7
  AST_RW_NO_FALSE: assert property (@(posedge clk) disable iff (!rst_n) !rw_cond |=> !clash_rw); // R8
  AST_WW_NO_FALSE: assert property (@(posedge clk) disable iff (!rst_n) !ww_cond |=> !clash_ww); // R8
  AST_RD_STBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) rd_stby |=> $stable(rd_data)); // R5
  AST_RD_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> $stable(rd_data)); // R9

endmodule

bind triport_regfile triport_regfile_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (.*);

// File: tb/triport_regfile_bench.sv
module triport_regfile_bench;
  localparam int PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int WIDTH = 8;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic rd_en = 0, rd_stby = 0, wr_stby = 0, wr0_en = 0, wr1_en = 0;
  logic [AW-1:0] rd_addr = '0, wr0_addr = '0, wr1_addr = '0;
  logic [WIDTH-1:0] wr0_data = '0, wr1_data = '0;
  logic [WIDTH-1:0] rd_data;
  logic clash_rw, clash_ww;

  triport_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_triport_regfile (.*);

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    logic [WIDTH-1:0] d;
    bit chk;
    bit rw;
    bit ww;
    string tag;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  logic [WIDTH-1:0] model [DEPTH];
  bit mvalid [DEPTH];
  logic [WIDTH-1:0] mout;
  bit mout_ok;

  task automatic check(string tag, string what, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit re, bit rs, int ra, bit ws,
                     bit e0, int a0, int d0, bit e1, int a1, int d1, string tag);
    item_t it;
    bit rw, ww;
    @(negedge clk);
    rd_en = re; rd_stby = rs; rd_addr = AW'(ra); wr_stby = ws;
    wr0_en = e0; wr0_addr = AW'(a0); wr0_data = WIDTH'(d0);
    wr1_en = e1; wr1_addr = AW'(a1); wr1_data = WIDTH'(d1);
    rw = re && !rs && !ws && ((e0 && a0 == ra) || (e1 && a1 == ra));
    ww = !ws && e0 && e1 && a0 == a1;
    if (re && !rs) begin
      if (rw) mout_ok = 0;
      else begin mout = model[ra]; mout_ok = mvalid[ra]; end
    end
    if (!ws) begin
      if (ww) mvalid[a0] = 0;
      else begin
        if (e0) begin model[a0] = WIDTH'(d0); mvalid[a0] = 1; end
        if (e1) begin model[a1] = WIDTH'(d1); mvalid[a1] = 1; end
      end
    end
    it.d = mout; it.chk = mout_ok; it.rw = rw; it.ww = ww; it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #(PERIOD/4);
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.chk) check(it.tag, "rd_data", rd_data, it.d);
      check(it.tag, "clash_rw", WIDTH'(clash_rw), WIDTH'(it.rw));
      check(it.tag, "clash_ww", WIDTH'(clash_ww), WIDTH'(it.ww));
    end
  end

  task automatic rd(int a, string tag);
    cyc(1, 0, a, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mvalid[i] = 0;
    mout = '0; mout_ok = 1;
    repeat (3) @(negedge clk);
    check("R1", "rd_data in reset", rd_data, '0);
    check("R1", "clash_rw in reset", WIDTH'(clash_rw), '0);
    check("R1", "clash_ww in reset", WIDTH'(clash_ww), '0);
    rst_n = 1;
    #1;
    check("R1", "rd_data after reset", rd_data, '0);

    for (int i = 0; i < DEPTH; i += 2)
      cyc(0, 0, 0, 0, 1, i, 8'h30 + i, 1, i + 1, 8'h30 + i + 1, "R3");
    for (int i = 0; i < DEPTH; i++) rd(i, "R2");
    rd(5, "R2");
    cyc(0, 0, 9, 0, 0, 0, 0, 0, 0, 0, "R9");
    cyc(0, 0, 2, 0, 0, 0, 0, 0, 0, 0, "R9");

    cyc(0, 0, 0, 1, 1, 3, 8'hEE, 1, 4, 8'hDD, "R4");
    cyc(0, 0, 0, 1, 1, 6, 8'hAA, 1, 6, 8'hBB, "R4");
    rd(3, "R4"); rd(4, "R4"); rd(6, "R4");

    rd(7, "R5");
    cyc(1, 1, 8, 0, 0, 0, 0, 0, 0, 0, "R5");
    cyc(1, 1, 1, 0, 1, 7, 8'h77, 0, 0, 0, "R5");
    cyc(1, 1, 2, 0, 1, 2, 8'h12, 0, 0, 0, "R8");
    rd(7, "R5");
    rd(2, "R8");

    cyc(1, 0, 10, 0, 1, 10, 8'h5A, 0, 0, 0, "R6");
    cyc(1, 0, 11, 0, 0, 0, 0, 1, 11, 8'h5B, "R6");
    rd(11, "R6");
    rd(10, "R6");
    cyc(1, 0, 12, 1, 1, 12, 8'h99, 0, 0, 0, "R8");
    rd(12, "R8");
    cyc(1, 0, 13, 0, 1, 14, 8'h44, 1, 15, 8'h55, "R8");
    rd(14, "R8"); rd(15, "R8");

    cyc(0, 0, 0, 0, 1, 9, 8'h01, 1, 9, 8'h02, "R7");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 1, 9, 8'hC3, 0, 0, 0, "R3");
    rd(9, "R7");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule